// File: doc/BRIEF.md
# User-Mode Trap Delegation Filter

This block holds the two supervisor-level delegation masks, one for exceptions and one for interrupts, that let supervisor software hand selected traps down to a user-mode handler. It also makes the routing decision for an incoming trap. Each mask has one bit per cause index, in the same layout as the machine-level masks. Supervisor software can set a bit only where machine software has already handed that cause to supervisor mode. A bit read back through the CSR port is always the stored bit ANDed with the live machine mask.

For each trap the decision asks two things: is the hart running in user mode, and is the delegation bit for that cause set? The interrupt flag picks the exception or the interrupt mask, and the cause index picks the bit. When the design is built without supervisor mode, the machine masks decide on their own and the supervisor registers read as zero. The CSR ports and the trap query are plain control pins with no handshake. The read data and the routing decision are combinational.

Top module: `trap_user_deleg`

## Requirements
- R1: After reset both supervisor masks read zero, and `to_user` is 0 for every cause while supervisor mode is present.
- R2: A write stores only those bits of `csr_wr_data` whose matching bit is set in the selected machine mask. `csr_wr_sel` = 0 selects the exception mask and 1 selects the interrupt mask. The write takes effect at the next rising clock edge.
- R3: `csr_rd_data` equals the stored mask ANDed with the current machine mask, in the same cycle. A machine bit that is cleared after a write reads as zero at once, and it shows the stored bit again when it is set once more. `csr_rd_sel` uses the same encoding as `csr_wr_sel`.
- R4: A write to one mask leaves the other mask unchanged.
- R5: `to_user` is 1 only when `trap_valid` is 1 and `cur_priv` is user mode. The privilege encoding is 2'b00 for user, 2'b01 for supervisor and 2'b11 for machine.
- R6: With supervisor mode present, `to_user` equals the readable supervisor bit at index `trap_cause`. That bit comes from the interrupt mask when `trap_irq` is 1 and from the exception mask when it is 0.
- R7: With supervisor mode absent, `to_user` equals bit `trap_cause` of `mdeleg_irq` or `mdeleg_exc`, chosen by `trap_irq`. `csr_rd_data` is always zero and writes have no effect.
- R8: In cycles without a write, both stored masks hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mdeleg_exc | input | XLEN | Machine exception delegation mask |
| mdeleg_irq | input | XLEN | Machine interrupt delegation mask |
| csr_wr_en | input | 1 | CSR write strobe |
| csr_wr_sel | input | 1 | Write target: 0 exception, 1 interrupt |
| csr_wr_data | input | XLEN | CSR write data |
| csr_rd_sel | input | 1 | Read source: 0 exception, 1 interrupt |
| csr_rd_data | output | XLEN | Readable supervisor mask |
| cur_priv | input | 2 | Current privilege mode |
| trap_valid | input | 1 | A trap is being considered |
| trap_irq | input | 1 | Trap is an interrupt |
| trap_cause | input | clog2(XLEN) | Trap cause index |
| to_user | output | 1 | Deliver to the user-mode handler |

## Verification
The bench runs an 8-bit configuration against every possible machine mask. It gives the two masks complementary machine masks and writes a different data pattern to each, so a write or read that reaches the wrong register shows up. After each write it changes the machine mask without writing again, which separates a design that ANDs on read from one that only filters the write. For every cause, both interrupt flag values and all three privilege modes, the decision is compared with an instance built without supervisor mode, so the two routing rules and the user-mode gate are each exposed.

// File: rtl/trap_deleg_pkg.sv
package trap_deleg_pkg;
  typedef enum logic [1:0] {
    PRIV_U = 2'b00,
    PRIV_S = 2'b01,
    PRIV_M = 2'b11
  } priv_e;

  localparam logic SEL_EXC = 1'b0;
  localparam logic SEL_IRQ = 1'b1;
endpackage

// File: rtl/deleg_mask_reg.sv
module deleg_mask_reg #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [XLEN-1:0] wr_data,
  input  logic [XLEN-1:0] mmask,
  output logic [XLEN-1:0] eff
);
  logic [XLEN-1:0] stored_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stored_q <= '0;
    end else if (wr_en) begin
      stored_q <= wr_data & mmask;
    end
  end

  assign eff = stored_q & mmask;

  // R2: a write can set nothing outside the written data or the machine mask
  assert_write_filtered_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (((stored_q & ~$past(wr_data)) == '0) && ((stored_q & ~$past(mmask)) == '0)));

  // R8: storage holds without a write
  assert_hold_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(stored_q));
endmodule

// File: rtl/deleg_route.sv
module deleg_route
  import trap_deleg_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int CW = (XLEN > 1) ? $clog2(XLEN) : 1
) (
  input  logic [1:0]      cur_priv,
  input  logic            trap_valid,
  input  logic            trap_irq,
  input  logic [CW-1:0]   trap_cause,
  input  logic [XLEN-1:0] exc_vec,
  input  logic [XLEN-1:0] irq_vec,
  output logic            to_user
);
  logic [XLEN-1:0] pick_vec;
  logic            in_user;

  always_comb begin
    pick_vec = trap_irq ? irq_vec : exc_vec;
    in_user  = (priv_e'(cur_priv) == PRIV_U);
    to_user  = trap_valid && in_user && pick_vec[trap_cause];
  end
endmodule

// File: rtl/trap_user_deleg.sv
module trap_user_deleg
  import trap_deleg_pkg::*;
#(
  parameter int XLEN = 32,
  parameter bit HAS_SMODE = 1'b1,
  localparam int CW = (XLEN > 1) ? $clog2(XLEN) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] mdeleg_exc,
  input  logic [XLEN-1:0] mdeleg_irq,
  input  logic            csr_wr_en,
  input  logic            csr_wr_sel,
  input  logic [XLEN-1:0] csr_wr_data,
  input  logic            csr_rd_sel,
  output logic [XLEN-1:0] csr_rd_data,
  input  logic [1:0]      cur_priv,
  input  logic            trap_valid,
  input  logic            trap_irq,
  input  logic [CW-1:0]   trap_cause,
  output logic            to_user
);
  logic [XLEN-1:0] exc_eff;
  logic [XLEN-1:0] irq_eff;
  logic [XLEN-1:0] route_exc;
  logic [XLEN-1:0] route_irq;

  if (HAS_SMODE) begin : g_smode
    deleg_mask_reg #(.XLEN(XLEN)) u_exc (
      .clk(clk), .rst_n(rst_n),
      .wr_en(csr_wr_en && (csr_wr_sel == SEL_EXC)),
      .wr_data(csr_wr_data), .mmask(mdeleg_exc), .eff(exc_eff)
    );
    deleg_mask_reg #(.XLEN(XLEN)) u_irq (
      .clk(clk), .rst_n(rst_n),
      .wr_en(csr_wr_en && (csr_wr_sel == SEL_IRQ)),
      .wr_data(csr_wr_data), .mmask(mdeleg_irq), .eff(irq_eff)
    );
    assign route_exc = exc_eff;
    assign route_irq = irq_eff;
  end else begin : g_no_smode
    assign exc_eff   = '0;
    assign irq_eff   = '0;
    assign route_exc = mdeleg_exc;
    assign route_irq = mdeleg_irq;
  end

  assign csr_rd_data = (csr_rd_sel == SEL_IRQ) ? irq_eff : exc_eff;

  deleg_route #(.XLEN(XLEN)) u_route (
    .cur_priv(cur_priv), .trap_valid(trap_valid), .trap_irq(trap_irq),
    .trap_cause(trap_cause), .exc_vec(route_exc), .irq_vec(route_irq),
    .to_user(to_user)
  );

  // R3: readable bits never exceed the live machine mask
  assert_read_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rd_data & ~((csr_rd_sel == SEL_IRQ) ? mdeleg_irq : mdeleg_exc)) == '0);

  // R5: user delivery only for a valid trap taken in user mode
  assert_user_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    to_user |-> (trap_valid && (cur_priv == 2'b00)));

  // R6/R7: delivery implies the delegating bit is set in the machine mask
  assert_machine_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    to_user |-> (trap_irq ? mdeleg_irq[trap_cause] : mdeleg_exc[trap_cause]));

  if (!HAS_SMODE) begin : g_chk_no_s
    // R7: without supervisor mode the CSR view is empty
    assert_no_s_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      csr_rd_data == '0);
  end
endmodule

// File: tb/trap_user_deleg_tb_top.sv
`timescale 1ns/1ps
module trap_user_deleg_tb_top;
  localparam int XL = 8;
  localparam int CWB = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic [XL-1:0] mdeleg_exc, mdeleg_irq, wr_data, rd_s, rd_n;
  logic wr_en, wr_sel, rd_sel, trap_valid, trap_irq, tu_s, tu_n;
  logic [1:0] cur_priv;
  logic [CWB-1:0] trap_cause;
  int n_run = 0;
  int n_fail = 0;
  bit done = 0;
  logic [XL-1:0] se, si;

  always #5 clk = ~clk;

  trap_user_deleg #(.XLEN(XL), .HAS_SMODE(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .mdeleg_exc(mdeleg_exc), .mdeleg_irq(mdeleg_irq),
    .csr_wr_en(wr_en), .csr_wr_sel(wr_sel), .csr_wr_data(wr_data),
    .csr_rd_sel(rd_sel), .csr_rd_data(rd_s), .cur_priv(cur_priv),
    .trap_valid(trap_valid), .trap_irq(trap_irq), .trap_cause(trap_cause),
    .to_user(tu_s));

  trap_user_deleg #(.XLEN(XL), .HAS_SMODE(1'b0)) dut_ns_i (
    .clk(clk), .rst_n(rst_n), .mdeleg_exc(mdeleg_exc), .mdeleg_irq(mdeleg_irq),
    .csr_wr_en(wr_en), .csr_wr_sel(wr_sel), .csr_wr_data(wr_data),
    .csr_rd_sel(rd_sel), .csr_rd_data(rd_n), .cur_priv(cur_priv),
    .trap_valid(trap_valid), .trap_irq(trap_irq), .trap_cause(trap_cause),
    .to_user(tu_n));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic sel, input logic [XL-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk_read(input logic sel, input logic [XL-1:0] exp, input string req);
    rd_sel = sel; #1;
    chk(rd_s == exp, req, int'(rd_s), int'(exp));
    chk(rd_n == '0, "R7 read", int'(rd_n), 0);
  endtask

  task automatic sweep_decisions();
    logic [XL-1:0] ee, ie;
    logic es, en;
    ee = se & mdeleg_exc;
    ie = si & mdeleg_irq;
    for (int p = 0; p < 3; p++) begin
      cur_priv = (p == 0) ? 2'b00 : ((p == 1) ? 2'b01 : 2'b11);
      for (int q = 0; q < 2; q++) begin
        trap_irq = q[0];
        for (int c = 0; c < XL; c++) begin
          trap_cause = CWB'(c);
          trap_valid = 1'b1; #1;
          es = (p == 0) && (q == 1 ? ie[c] : ee[c]);
          en = (p == 0) && (q == 1 ? mdeleg_irq[c] : mdeleg_exc[c]);
          chk(tu_s == es, "R6 supervisor route", int'(tu_s), int'(es));
          chk(tu_n == en, "R7 machine route", int'(tu_n), int'(en));
          trap_valid = 1'b0; #1;
          chk(tu_s == 1'b0 && tu_n == 1'b0, "R5 invalid trap", int'(tu_s | tu_n), 0);
        end
      end
    end
  endtask

  initial begin
    #(1_500_000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hang expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [XL-1:0] m, w1, w2;
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0; rd_sel = 1'b0;
    mdeleg_exc = '1; mdeleg_irq = '1; cur_priv = 2'b00;
    trap_valid = 1'b0; trap_irq = 1'b0; trap_cause = '0;
    se = '0; si = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk_read(1'b0, 8'h00, "R1 exc reset");
    chk_read(1'b1, 8'h00, "R1 irq reset");
    for (int c = 0; c < XL; c++) begin
      trap_cause = CWB'(c); trap_irq = c[0]; trap_valid = 1'b1; #1;
      chk(tu_s == 1'b0, "R1 no delivery", int'(tu_s), 0);
    end
    trap_valid = 1'b0;

    for (int k = 0; k < 256; k++) begin
      m = XL'(k);
      mdeleg_exc = m; mdeleg_irq = ~m;
      w1 = XL'((k * 37 + 11) & 255);
      w2 = XL'((k * 91 + 5) & 255);
      do_write(1'b0, w1);
      se = w1 & m;
      chk_read(1'b0, se, "R2 exc write");
      chk_read(1'b1, si & ~m, "R4 irq untouched");
      do_write(1'b1, w2);
      si = w2 & ~m;
      chk_read(1'b1, si, "R2 irq write");
      chk_read(1'b0, se, "R4 exc untouched");
      // R3: machine mask changes with no write
      mdeleg_exc = m ^ 8'h5A;
      chk_read(1'b0, se & (m ^ 8'h5A), "R3 live mask");
      mdeleg_exc = m;
      chk_read(1'b0, se, "R3 mask restored");
      mdeleg_exc = m ^ 8'h5A;
      sweep_decisions();
    end

    // R8: idle cycles keep the stored values
    mdeleg_exc = '1; mdeleg_irq = '1;
    repeat (5) @(negedge clk);
    chk_read(1'b0, se, "R8 exc hold");
    chk_read(1'b1, si, "R8 irq hold");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule